// File: doc/BRIEF.md
# Slave-Serial Configuration Loader

This block loads a configuration bitstream into a target FPGA through the target's slave-serial pins. It takes bytes from a streaming source over a valid/ready handshake and turns them into a pin sequence. First it drives an active-low program line low for a fixed time. Then it waits, with a time limit, for the target's init line to rise. After that it shifts every byte out serially, most significant bit first, on a data pin and a configuration clock that it generates itself.

When the byte flagged as last has been sent, the loader checks the init line for a CRC failure and gives four extra configuration clocks. It then checks the done line. On success it drives an active-low reset into the freshly loaded design for a set time. Busy is high for the whole sequence. When the sequence ends, exactly one of four result flags is raised: success, init timeout, CRC error or missing done. That flag stays up until the next accepted start.

All pin timings are parameters counted in system clock cycles, and their defaults are derived from a clock-frequency parameter. The init and done inputs pass through two-flop synchronizers before the control logic uses them.

Top module: `cfg_serial_loader`

## Requirements
- R1: After reset the loader is idle. cfgProgN, userRstN = 1. cfgClk, busy, inReady and all four result flags = 0.
- R2: An accepted start drives cfgProgN low for exactly PROG_CYC system cycles, once per accepted start. It then drives cfgProgN high again.
- R3: If synchronized init has not gone high within INIT_TO_CYC cycles after cfgProgN is released, the loader raises resTimeout. In that case it requests no byte and gives no configuration clock.
- R4: Each data bit uses one configuration clock period. cfgClk goes low for HALF_CYC cycles and then high for HALF_CYC cycles. cfgData changes only in cycles where cfgClk is low, so it is stable at every rising edge.
- R5: The bits of each byte come out most significant bit first, and the bytes come out in the order they were accepted.
- R6: inReady is high only while the loader waits for the next byte. It is low while a byte is being shifted. After the byte marked with inLast has been taken, no further byte is requested.
- R7: If synchronized init is low once the final data bit has been sent, the run ends with resCrcErr.
- R8: Every run that reaches the end of the data gives exactly four further rising edges of cfgClk after the last data bit.
- R9: If synchronized done is low after the trailing clocks and no CRC error was seen, the run ends with resNoDone. A CRC error takes priority over a missing done.
- R10: On success the loader drives userRstN low for exactly RST_CYC cycles and raises resOk after that. Failing runs never drive userRstN low.
- R11: A finished run shows exactly one result flag while busy is low. The flag is held until the next accepted start.
- R12: A start pulse while busy has no effect on the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a load sequence (taken only when idle) |
| inByte | input | BYTE_W | Bitstream byte |
| inValid | input | 1 | inByte is valid |
| inLast | input | 1 | Marks the final byte of the stream |
| inReady | output | 1 | Loader accepts a byte this cycle |
| cfgProgN | output | 1 | Active-low program line to the target |
| cfgClk | output | 1 | Configuration clock to the target |
| cfgData | output | 1 | Serial configuration data |
| cfgInit | input | 1 | Init status line from the target (asynchronous) |
| cfgDone | input | 1 | Done status line from the target (asynchronous) |
| userRstN | output | 1 | Active-low reset to the loaded design |
| busy | output | 1 | Sequence in progress |
| resOk | output | 1 | Last run succeeded |
| resTimeout | output | 1 | Last run timed out waiting for init |
| resCrcErr | output | 1 | Last run saw init low after the data |
| resNoDone | output | 1 | Last run saw done low after the trailing clocks |

## Verification
A behavioural target model samples cfgData on each rising cfgClk and feeds a scoreboard of expected bytes. One stream alternates 0x80 and 0x01, so a reversed bit order cannot hide, and other streams use mixed values, source stalls and a one-byte stream. The target model is also switched between four behaviours: healthy, init dropped after the data, done never rising, and init never rising. These tell the four outcomes apart, check that CRC takes priority and show that the trailing-clock count holds in every outcome. A duplicate start during a run, and a clean load straight after a timeout, show that the sequence neither restarts nor carries state over from one run to the next.

// File: rtl/cfgload_pkg.sv
package cfgload_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_PROG,
    S_WAITI,
    S_FETCH,
    S_LO,
    S_HI,
    S_CHECK,
    S_TLO,
    S_THI,
    S_EVAL,
    S_URST
  } ldState_e;

  // Strobes from the control to the pin datapath
  typedef struct packed {
    logic progLow;
    logic progHigh;
    logic loadByte;
    logic shiftBit;
    logic clkLow;
    logic clkHigh;
    logic rstLow;
    logic rstHigh;
  } dpStrobe_t;

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/cfgload_sync.sv
module cfgload_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= '0;
    end else begin
      stage[0] <= din;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign dout = stage[STAGES-1];
endmodule

// File: rtl/cfgload_datapath.sv
module cfgload_datapath
  import cfgload_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic [BYTE_W-1:0] inByte,
  input  logic              inLast,
  input  logic              cfgInit,
  input  logic              cfgDone,
  output logic              cfgProgN,
  output logic              cfgClk,
  output logic              cfgData,
  output logic              userRstN,
  output logic              initS,
  output logic              doneS,
  output logic              lastQ
);
  logic              progQ, clkQ, dataQ, urstQ;
  logic [BYTE_W-1:0] shiftQ;
  logic [1:0]        syncOut;

  cfgload_sync #(.WIDTH(2), .STAGES(SYNC_N)) statusSync_i (
    .clk  (clk),
    .rstN (rstN),
    .din  ({cfgDone, cfgInit}),
    .dout (syncOut)
  );
  assign initS = syncOut[0];
  assign doneS = syncOut[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      progQ  <= 1'b1;
      clkQ   <= 1'b0;
      dataQ  <= 1'b0;
      urstQ  <= 1'b1;
      shiftQ <= '0;
      lastQ  <= 1'b0;
    end else begin
      if (stb.progLow)  progQ <= 1'b0;
      if (stb.progHigh) progQ <= 1'b1;
      if (stb.loadByte) begin
        // MSB goes straight to the pin, the rest waits pre-shifted
        dataQ  <= inByte[BYTE_W-1];
        shiftQ <= {inByte[BYTE_W-2:0], 1'b0};
        lastQ  <= inLast;
      end
      if (stb.shiftBit) begin
        dataQ  <= shiftQ[BYTE_W-1];
        shiftQ <= {shiftQ[BYTE_W-2:0], 1'b0};
      end
      if (stb.clkLow)  clkQ  <= 1'b0;
      if (stb.clkHigh) clkQ  <= 1'b1;
      if (stb.rstLow)  urstQ <= 1'b0;
      if (stb.rstHigh) urstQ <= 1'b1;
    end
  end

  assign cfgProgN = progQ;
  assign cfgClk   = clkQ;
  assign cfgData  = dataQ;
  assign userRstN = urstQ;

  // R4: data may move only while the configuration clock is low
  p_data_moves_low_r4: assert property (@(posedge clk) disable iff (!rstN)
    (cfgData != $past(cfgData)) |-> !cfgClk);

  // R4: data is unchanged across each rising configuration edge
  p_rise_stable_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cfgClk) |-> $stable(cfgData));

  // R10: the user reset is never applied while the target is being programmed
  p_urst_not_prog_r10: assert property (@(posedge clk) disable iff (!rstN)
    !userRstN |-> cfgProgN);
endmodule

// File: rtl/cfgload_ctrl.sv
module cfgload_ctrl
  import cfgload_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int PROG_CYC    = 32,
  parameter int INIT_TO_CYC = 500000,
  parameter int HALF_CYC    = 2,
  parameter int RST_CYC     = 200,
  parameter int TRAIL_N     = 4,
  parameter int SETTLE_CYC  = 3
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      inValid,
  input  logic      initS,
  input  logic      doneS,
  input  logic      lastQ,
  output dpStrobe_t stb,
  output logic      inReady,
  output logic      busy,
  output logic      resOk,
  output logic      resTimeout,
  output logic      resCrcErr,
  output logic      resNoDone
);
  localparam int CNT_MAX = maxOf(maxOf(maxOf(PROG_CYC, INIT_TO_CYC), maxOf(HALF_CYC, RST_CYC)),
                                 SETTLE_CYC);
  localparam int CNT_W = $clog2(CNT_MAX + 1);
  localparam int BIT_W = $clog2(BYTE_W);
  localparam int TR_W  = $clog2(TRAIL_N + 1);

  localparam logic [CNT_W-1:0] C_PROG   = CNT_W'(PROG_CYC - 1);
  localparam logic [CNT_W-1:0] C_INIT   = CNT_W'(INIT_TO_CYC - 1);
  localparam logic [CNT_W-1:0] C_HALF   = CNT_W'(HALF_CYC - 1);
  localparam logic [CNT_W-1:0] C_RST    = CNT_W'(RST_CYC - 1);
  localparam logic [CNT_W-1:0] C_SETTLE = CNT_W'(SETTLE_CYC - 1);
  localparam logic [BIT_W-1:0] C_BITS   = BIT_W'(BYTE_W - 1);
  localparam logic [TR_W-1:0]  C_TRAIL  = TR_W'(TRAIL_N - 1);

  ldState_e         st, stNext;
  logic [CNT_W-1:0] cnt, cntNext;
  logic [BIT_W-1:0] bitLeft, bitNext;
  logic [TR_W-1:0]  trailLeft, trailNext;
  logic             crcBad, crcNext;
  logic [3:0]       resQ, resNext;    // {noDone, crc, timeout, ok}
  logic             cntZero;

  assign cntZero = (cnt == '0);

  always_comb begin
    stNext    = st;
    cntNext   = cntZero ? cnt : cnt - 1'b1;
    bitNext   = bitLeft;
    trailNext = trailLeft;
    crcNext   = crcBad;
    resNext   = resQ;
    stb       = '0;
    unique case (st)
      S_IDLE: begin
        cntNext = cnt;
        if (start) begin
          stNext      = S_PROG;
          cntNext     = C_PROG;
          resNext     = '0;
          crcNext     = 1'b0;
          stb.progLow = 1'b1;
        end
      end
      S_PROG: if (cntZero) begin
        stb.progHigh = 1'b1;
        stNext       = S_WAITI;
        cntNext      = C_INIT;
      end
      S_WAITI: begin
        if (initS) begin
          stNext = S_FETCH;
        end else if (cntZero) begin
          stNext     = S_IDLE;
          resNext[1] = 1'b1;
        end
      end
      S_FETCH: begin
        cntNext = cnt;
        if (inValid) begin
          stb.loadByte = 1'b1;
          stb.clkLow   = 1'b1;
          bitNext      = C_BITS;
          cntNext      = C_HALF;
          stNext       = S_LO;
        end
      end
      S_LO: if (cntZero) begin
        stb.clkHigh = 1'b1;
        cntNext     = C_HALF;
        stNext      = S_HI;
      end
      S_HI: if (cntZero) begin
        if (bitLeft != '0) begin
          stb.shiftBit = 1'b1;
          stb.clkLow   = 1'b1;
          bitNext      = bitLeft - 1'b1;
          cntNext      = C_HALF;
          stNext       = S_LO;
        end else if (lastQ) begin
          cntNext = C_SETTLE;
          stNext  = S_CHECK;
        end else begin
          stNext = S_FETCH;
        end
      end
      S_CHECK: if (cntZero) begin
        crcNext    = !initS;
        trailNext  = C_TRAIL;
        stb.clkLow = 1'b1;
        cntNext    = C_HALF;
        stNext     = S_TLO;
      end
      S_TLO: if (cntZero) begin
        stb.clkHigh = 1'b1;
        cntNext     = C_HALF;
        stNext      = S_THI;
      end
      S_THI: if (cntZero) begin
        stb.clkLow = 1'b1;
        if (trailLeft != '0) begin
          trailNext = trailLeft - 1'b1;
          cntNext   = C_HALF;
          stNext    = S_TLO;
        end else begin
          cntNext = C_SETTLE;
          stNext  = S_EVAL;
        end
      end
      S_EVAL: if (cntZero) begin
        if (crcBad) begin
          resNext[2] = 1'b1;
          stNext     = S_IDLE;
        end else if (!doneS) begin
          resNext[3] = 1'b1;
          stNext     = S_IDLE;
        end else begin
          stb.rstLow = 1'b1;
          cntNext    = C_RST;
          stNext     = S_URST;
        end
      end
      S_URST: if (cntZero) begin
        stb.rstHigh = 1'b1;
        resNext[0]  = 1'b1;
        stNext      = S_IDLE;
      end
      default: stNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st        <= S_IDLE;
      cnt       <= '0;
      bitLeft   <= '0;
      trailLeft <= '0;
      crcBad    <= 1'b0;
      resQ      <= '0;
    end else begin
      st        <= stNext;
      cnt       <= cntNext;
      bitLeft   <= bitNext;
      trailLeft <= trailNext;
      crcBad    <= crcNext;
      resQ      <= resNext;
    end
  end

  assign busy       = (st != S_IDLE);
  assign inReady    = (st == S_FETCH);
  assign resOk      = resQ[0];
  assign resTimeout = resQ[1];
  assign resCrcErr  = resQ[2];
  assign resNoDone  = resQ[3];

  // R11: never more than one outcome
  p_one_result_r11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({resNoDone, resCrcErr, resTimeout, resOk}));

  // R11: outcomes are only shown while idle
  p_result_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    (resOk || resTimeout || resCrcErr || resNoDone) |-> !busy);

  // R12: the program phase is entered only from idle
  p_no_restart_r12: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (st != S_PROG || $past(st) == S_PROG));

  // R3: a timeout can only come out of the init wait
  p_timeout_from_wait_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(resTimeout) |-> $past(st) == S_WAITI);

  // R10: success is declared only after the user reset phase
  p_ok_after_urst_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(resOk) |-> $past(st) == S_URST);

  // R9: missing done is never reported over a CRC error
  p_crc_priority_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(resNoDone) |-> !crcBad);

  // R6: no byte is taken while a bit is on the wire
  p_ready_not_shifting_r6: assert property (@(posedge clk) disable iff (!rstN)
    (st == S_LO || st == S_HI) |-> !inReady);
endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader
  import cfgload_pkg::*;
#(
  parameter int CLK_HZ      = 100_000_000,
  parameter int BYTE_W      = 8,
  parameter int PROG_CYC    = (CLK_HZ / 10_000_000) * 3 + 2,
  parameter int INIT_TO_CYC = CLK_HZ / 200,
  parameter int HALF_CYC    = (CLK_HZ / 50_000_000 > 0) ? CLK_HZ / 50_000_000 : 1,
  parameter int RST_CYC     = CLK_HZ / 500_000,
  parameter int TRAIL_N     = 4,
  parameter int SYNC_N      = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [BYTE_W-1:0] inByte,
  input  logic              inValid,
  input  logic              inLast,
  output logic              inReady,
  output logic              cfgProgN,
  output logic              cfgClk,
  output logic              cfgData,
  input  logic              cfgInit,
  input  logic              cfgDone,
  output logic              userRstN,
  output logic              busy,
  output logic              resOk,
  output logic              resTimeout,
  output logic              resCrcErr,
  output logic              resNoDone
);
  localparam int SETTLE_CYC = SYNC_N + 1;

  dpStrobe_t stb;
  logic      initS, doneS, lastQ;

  cfgload_ctrl #(
    .BYTE_W      (BYTE_W),
    .PROG_CYC    (PROG_CYC),
    .INIT_TO_CYC (INIT_TO_CYC),
    .HALF_CYC    (HALF_CYC),
    .RST_CYC     (RST_CYC),
    .TRAIL_N     (TRAIL_N),
    .SETTLE_CYC  (SETTLE_CYC)
  ) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .inValid    (inValid),
    .initS      (initS),
    .doneS      (doneS),
    .lastQ      (lastQ),
    .stb        (stb),
    .inReady    (inReady),
    .busy       (busy),
    .resOk      (resOk),
    .resTimeout (resTimeout),
    .resCrcErr  (resCrcErr),
    .resNoDone  (resNoDone)
  );

  cfgload_datapath #(
    .BYTE_W (BYTE_W),
    .SYNC_N (SYNC_N)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .inByte   (inByte),
    .inLast   (inLast),
    .cfgInit  (cfgInit),
    .cfgDone  (cfgDone),
    .cfgProgN (cfgProgN),
    .cfgClk   (cfgClk),
    .cfgData  (cfgData),
    .userRstN (userRstN),
    .initS    (initS),
    .doneS    (doneS),
    .lastQ    (lastQ)
  );
endmodule

// File: tb/cfg_serial_loader_tb_top.sv
module cfg_serial_loader_tb_top;
  localparam int P_PROG = 8;
  localparam int P_INIT = 300;
  localparam int P_HALF = 3;
  localparam int P_RST  = 10;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0;
  logic [7:0] inByte = '0;
  logic inValid = 1'b0, inLast = 1'b0, inReady;
  logic cfgProgN, cfgClk, cfgData, userRstN, busy;
  logic cfgInit = 1'b0, cfgDone = 1'b0;
  logic resOk, resTimeout, resCrcErr, resNoDone;

  always #5 clk = ~clk;

  cfg_serial_loader #(
    .PROG_CYC(P_PROG), .INIT_TO_CYC(P_INIT), .HALF_CYC(P_HALF), .RST_CYC(P_RST)
  ) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .inByte(inByte), .inValid(inValid),
    .inLast(inLast), .inReady(inReady), .cfgProgN(cfgProgN), .cfgClk(cfgClk),
    .cfgData(cfgData), .cfgInit(cfgInit), .cfgDone(cfgDone), .userRstN(userRstN),
    .busy(busy), .resOk(resOk), .resTimeout(resTimeout), .resCrcErr(resCrcErr),
    .resNoDone(resNoDone)
  );

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // ---------------- target model and scoreboard ----------------
  int fpgaMode = 0;           // 0 healthy, 1 crc, 2 no done, 3 no init
  int ictr = 0;
  logic [7:0] expQ[$];
  logic [7:0] acc = '0;
  int nb = 0, trailSeen = 0;
  bit dataComplete = 1'b0;

  always @(posedge cfgClk) begin
    if (expQ.size() > 0) begin
      acc = {acc[6:0], cfgData};
      nb++;
      if (nb == 8) begin
        logic [7:0] want;
        want = expQ.pop_front();
        nb = 0;
        check(acc == want, "R5", "serial byte", acc, want);
        if (expQ.size() == 0) dataComplete = 1'b1;
      end
    end else begin
      trailSeen++;
    end
  end

  always @(posedge clk) begin
    if (!cfgProgN) begin
      cfgInit <= 1'b0;
      ictr    <= 0;
    end else if (fpgaMode == 1 && dataComplete) begin
      cfgInit <= 1'b0;
    end else if (fpgaMode != 3) begin
      if (ictr >= 20) cfgInit <= 1'b1;
      else ictr <= ictr + 1;
    end
    cfgDone <= (fpgaMode == 0 && dataComplete && trailSeen >= 2);
  end

  // ---------------- pin monitor ----------------
  bit runActive = 1'b0, lastSent = 1'b0, sawFall = 1'b0;
  logic prevProg = 1'b1, prevClk = 1'b0, prevUrst = 1'b1;
  int progLowCyc, progFalls, rstLowCyc, rstFalls, readyMid, readyAfterLast;
  int readyCount, lowLen, lowBad, tCount;

  always @(negedge clk) begin
    if (runActive) begin
      if (!cfgProgN) progLowCyc++;
      if (prevProg && !cfgProgN) progFalls++;
      if (!userRstN) rstLowCyc++;
      if (prevUrst && !userRstN) rstFalls++;
      if (inReady) readyCount++;
      if (inReady && nb != 0) readyMid++;
      if (inReady && lastSent) readyAfterLast++;
      if (!cfgClk) begin
        if (prevClk) begin sawFall = 1'b1; lowLen = 1; end
        else lowLen++;
      end else if (!prevClk && sawFall && lowLen != P_HALF) begin
        lowBad++;
      end
      if (cfgProgN && progFalls > 0 && !(resOk || resTimeout || resCrcErr || resNoDone))
        tCount++;
    end
    prevProg = cfgProgN;
    prevClk  = cfgClk;
    prevUrst = userRstN;
  end

  function automatic logic [7:0] patByte(input int pat, input int k);
    if (pat == 0) return (k % 2 == 0) ? 8'h80 : 8'h01;
    return 8'((pat * 29 + k * 71 + 3) ^ (k * 13));
  endfunction

  // ---------------- driver ----------------
  task automatic run_case(input int mode, input int n, input int pat,
                          input int stall, input bit extraStart);
    int expRes;
    expQ.delete();
    nb = 0; trailSeen = 0; dataComplete = 1'b0; lastSent = 1'b0; sawFall = 1'b0;
    progLowCyc = 0; progFalls = 0; rstLowCyc = 0; rstFalls = 0; readyMid = 0;
    readyAfterLast = 0; readyCount = 0; lowLen = 0; lowBad = 0; tCount = 0;
    fpgaMode = mode;
    if (mode != 3) for (int k = 0; k < n; k++) expQ.push_back(patByte(pat, k));
    runActive = 1'b1;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    if (extraStart) begin
      repeat (4) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    if (mode != 3) begin
      for (int k = 0; k < n; k++) begin
        inByte = patByte(pat, k); inValid = 1'b1; inLast = (k == n - 1);
        while (!inReady) @(negedge clk);
        @(negedge clk);
        inValid = 1'b0; inLast = 1'b0;
        if (k == n - 1) lastSent = 1'b1;
        repeat (stall) @(negedge clk);
      end
    end
    while (!(resOk || resTimeout || resCrcErr || resNoDone)) @(negedge clk);
    expRes = (mode == 0) ? 1 : (mode == 3) ? 2 : (mode == 1) ? 4 : 8;
    check({resNoDone, resCrcErr, resTimeout, resOk} == 4'(expRes), "R11", "result flags",
          int'({resNoDone, resCrcErr, resTimeout, resOk}), expRes);
    check(!busy, "R11", "busy at result", int'(busy), 0);
    check(progLowCyc == P_PROG, "R2", "program low cycles", progLowCyc, P_PROG);
    check(progFalls == 1, "R12", "program pulses per run", progFalls, 1);
    if (mode == 3) begin
      check(tCount >= P_INIT && tCount <= P_INIT + 2, "R3", "timeout latency",
            tCount, P_INIT + 1);
      check(readyCount == 0, "R3", "bytes requested after timeout", readyCount, 0);
      check(trailSeen == 0, "R3", "clocks after timeout", trailSeen, 0);
    end else begin
      check(expQ.size() == 0 && nb == 0, "R5", "bytes left unsent", expQ.size(), 0);
      check(trailSeen == 4, "R8", "trailing clocks", trailSeen, 4);
      check(lowBad == 0, "R4", "low phases not HALF_CYC", lowBad, 0);
      check(readyMid == 0, "R6", "ready while shifting", readyMid, 0);
      check(readyAfterLast == 0, "R6", "ready after last byte", readyAfterLast, 0);
    end
    if (mode == 0) begin
      check(rstLowCyc == P_RST, "R10", "user reset low cycles", rstLowCyc, P_RST);
      check(userRstN == 1'b1, "R10", "user reset released at ok", int'(userRstN), 1);
    end else begin
      check(rstFalls == 0, "R10", "user reset on failing run", rstFalls, 0);
    end
    if (mode == 1) check(resCrcErr && !resNoDone, "R7", "crc flag", int'(resCrcErr), 1);
    if (mode == 2) check(resNoDone, "R9", "missing-done flag", int'(resNoDone), 1);
    repeat (6) @(negedge clk);
    check({resNoDone, resCrcErr, resTimeout, resOk} == 4'(expRes), "R11", "result held",
          int'({resNoDone, resCrcErr, resTimeout, resOk}), expRes);
    runActive = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(cfgProgN == 1'b1 && userRstN == 1'b1, "R1", "program/user reset high",
          int'({cfgProgN, userRstN}), 3);
    check(!cfgClk && !busy && !inReady, "R1", "clock/busy/ready low",
          int'({cfgClk, busy, inReady}), 0);
    check({resNoDone, resCrcErr, resTimeout, resOk} == 4'b0, "R1", "result flags",
          int'({resNoDone, resCrcErr, resTimeout, resOk}), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    run_case(0, 4, 0, 0, 1'b0);   // MSB-first pattern
    run_case(0, 6, 1, 5, 1'b1);   // stalls plus duplicate start (R12)
    run_case(0, 1, 2, 0, 1'b0);   // single byte stream
    run_case(1, 3, 3, 0, 1'b0);   // CRC error (R7)
    run_case(2, 3, 4, 1, 1'b0);   // done missing (R9)
    run_case(3, 0, 0, 0, 1'b0);   // init never rises (R3)
    run_case(0, 2, 5, 2, 1'b0);   // recovery after timeout
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R11 watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule